// File: doc/BRIEF.md
# I3C SDR Private Transfer Target Engine

This block is the target-side bit and byte engine for private reads and writes in single-data-rate mode. It works from one-cycle strobes that mark the SCL edges and the bus START and STOP conditions. It compares each frame header with the target's dynamic address. On a write frame it takes the first data byte as a register pointer and sends the bytes after it to a simple register port. On a read frame it streams register bytes back to the controller.

A transition bit follows every data byte, and the target drives it in both directions. On a write, 0 invites the controller to send more and 1 refuses further bytes once the configured maximum write length is reached. On a read, 0 announces another byte and 1 marks the last byte allowed by the maximum read length. The target never holds SCL. Each read byte after the first is fetched from the register port on the rising SCL edge of the preceding transition bit, so it is ready before the next falling edge.

The register pointer survives between frames and advances after each transferred byte. A write frame that carries only the pointer, followed by a repeated START and a read frame, therefore reads from the pointer just set.

Top module: `i3c_sdr_tgt`

## Requirements
- R1: The target acknowledges a header only when its upper 7 bits equal `dyn_addr` and `dyn_addr_vld` is 1. It acknowledges by driving SDA low in open-drain mode (`sda_oe`=1, `sda_o`=0, `sda_pp`=0) during the ninth bit. On any other header it drives nothing until the next START.
- R2: The first data byte of a write frame loads the register pointer and causes no register write.
- R3: Each later write byte is written once to the register at the pointer, and the pointer then advances by one. It wraps from all-ones to zero.
- R4: During write data bits the target drives nothing. The transition bit after write byte k, where the pointer byte counts as k=1, is driven push-pull. It is 0 while k < `max_wr_len` and 1 once k >= `max_wr_len`.
- R5: After a write transition bit of 1, every further bit of the frame is ignored: there is no register write and no SDA drive until START or STOP.
- R6: Read data is driven push-pull, MSB first. The first byte comes from the pointer and each later byte from the next address.
- R7: The transition bit after read byte k is driven push-pull. It is 0 while k < `max_rd_len` and 1 once k >= `max_rd_len`. After a 1 the target releases SDA at the next falling edge and sends nothing more in that frame.
- R8: The pointer keeps its value across frames, so a read frame after a repeated START continues from the pointer left by the previous frame.
- R9: A START at any bit position abandons the byte in progress, with no register write, and restarts header matching. A STOP releases SDA on the next clock.
- R10: Exactly one `reg_rd` pulse occurs for each read byte. The first occurs on the rising edge of the eighth header bit, and each later one on the rising edge of a transition bit of 0. None occurs on the rising edge of a transition bit of 1.
- R11: After reset `sda_oe`, `reg_wr` and `reg_rd` are 0. The SDA outputs change only in the clock after a `scl_fall`, `bus_start` or `bus_stop` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_rise | input | 1 | One-cycle strobe: SCL rising edge (sample point) |
| scl_fall | input | 1 | One-cycle strobe: SCL falling edge (drive point) |
| sda_in | input | 1 | Synchronised SDA line level |
| bus_start | input | 1 | One-cycle strobe: START or repeated START seen |
| bus_stop | input | 1 | One-cycle strobe: STOP seen |
| dyn_addr | input | 7 | Assigned dynamic address |
| dyn_addr_vld | input | 1 | Dynamic address has been assigned |
| max_wr_len | input | LEN_W | Maximum bytes per private write, pointer byte included |
| max_rd_len | input | LEN_W | Maximum bytes per private read |
| sda_oe | output | 1 | SDA drive enable |
| sda_o | output | 1 | SDA value when driven |
| sda_pp | output | 1 | 1 = push-pull drive, 0 = open-drain (low only) |
| reg_ptr | output | REG_AW | Register port address (current pointer) |
| reg_wr | output | 1 | Register write strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rd | output | 1 | Register read strobe; data taken in the same cycle |
| reg_rdata | input | 8 | Register read data, valid in the `reg_rd` cycle |

## Verification
The SDA outputs are registered, so a new bit value appears one clock after its `scl_fall` strobe. `reg_wr` and `reg_rd` are combinational with the `scl_rise` strobe that completes a byte or a transition bit. The bench raises a falling strobe and waits four clocks before it samples the line, which is just before the next rising strobe, so every driven value has settled. The register model and the strobe counters sample at the rising clock edge, where the combinational strobes are stable. A monitor flags any change of the SDA outputs in a clock that did not follow a falling, START or STOP strobe.

// File: rtl/i3c_tgt_pkg.sv
package i3c_tgt_pkg;
   localparam int BYTE_W = 8;
   localparam int HDR_AW = 7;
   localparam int BIT_W  = $clog2(BYTE_W);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_ACK,
      ST_WDAT,
      ST_WTB,
      ST_RDAT,
      ST_RTB,
      ST_HALT
   } tgt_st_e;
endpackage

// File: rtl/i3c_tgt_hdr_match.sv
module i3c_tgt_hdr_match #(
   parameter int AW = 7
) (
   input  logic [AW:0]   hdr_byte,
   input  logic [AW-1:0] own_addr,
   input  logic          own_vld,
   output logic          hit,
   output logic          rnw
);
   // header layout: address in the upper bits, direction in bit 0 (1 = read)
   assign hit = own_vld && (hdr_byte[AW:1] == own_addr);
   assign rnw = hdr_byte[0];
endmodule

// File: rtl/i3c_tgt_len_guard.sv
module i3c_tgt_len_guard #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             bump,
   input  logic [LEN_W-1:0] limit,
   output logic             none_yet,
   output logic             at_limit
);
   localparam logic [LEN_W-1:0] CNT_MAX = {LEN_W{1'b1}};

   logic [LEN_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= bump ? LEN_W'(1) : '0;
      end else if (bump && cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + LEN_W'(1);
      end
   end

   assign none_yet = (cnt_q == '0);
   assign at_limit = (cnt_q >= limit);
endmodule

// File: rtl/i3c_tgt_ptr.sv
module i3c_tgt_ptr #(
   parameter int AW       = 8,
   parameter bit AUTO_INC = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          step,
   output logic [AW-1:0] ptr
);
   generate
      if (AUTO_INC) begin : g_inc
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     ptr <= '0;
            else if (load)  ptr <= load_val;
            else if (step)  ptr <= ptr + AW'(1);
         end
      end else begin : g_fixed
         logic unused_step;
         assign unused_step = step;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     ptr <= '0;
            else if (load)  ptr <= load_val;
         end
      end
   endgenerate
endmodule

// File: rtl/i3c_sdr_tgt.sv
module i3c_sdr_tgt
   import i3c_tgt_pkg::*;
#(
   parameter int REG_AW   = 8,
   parameter int LEN_W    = 8,
   parameter bit AUTO_INC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_in,
   input  logic              bus_start,
   input  logic              bus_stop,
   input  logic [6:0]        dyn_addr,
   input  logic              dyn_addr_vld,
   input  logic [LEN_W-1:0]  max_wr_len,
   input  logic [LEN_W-1:0]  max_rd_len,
   output logic              sda_oe,
   output logic              sda_o,
   output logic              sda_pp,
   output logic [REG_AW-1:0] reg_ptr,
   output logic              reg_wr,
   output logic [7:0]        reg_wdata,
   output logic              reg_rd,
   input  logic [7:0]        reg_rdata
);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

   generate
      if (REG_AW < 1 || REG_AW > 16) begin : g_bad_aw
         $error("REG_AW must lie in 1..16");
      end
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("LEN_W must lie in 1..16");
      end
      if (REG_AW > BYTE_W) begin : g_bad_ptr
         $error("REG_AW cannot exceed the pointer byte width");
      end
   endgenerate

   tgt_st_e            st_q;
   logic [BIT_W-1:0]   bcnt_q;
   logic [BYTE_W-2:0]  rx_q;
   logic [BYTE_W-1:0]  tx_q;
   logic               rnw_q;

   logic [BYTE_W-1:0]  rx_byte;
   logic               ev_ok, last_bit;
   logic               hdr_done, hit, rnw;
   logic               wbyte_done, fetch_hdr, fetch_tb;
   logic               first_w, at_limit, ptr_load;
   logic [LEN_W-1:0]   lim_sel;

   assign rx_byte  = {rx_q, sda_in};
   assign ev_ok    = !bus_start && !bus_stop;
   assign last_bit = (bcnt_q == LAST_BIT);

   i3c_tgt_hdr_match #(.AW(HDR_AW)) u_match (
      .hdr_byte (rx_byte),
      .own_addr (dyn_addr),
      .own_vld  (dyn_addr_vld),
      .hit      (hit),
      .rnw      (rnw)
   );

   assign hdr_done   = ev_ok && scl_rise && last_bit && (st_q == ST_HDR);
   assign wbyte_done = ev_ok && scl_rise && last_bit && (st_q == ST_WDAT);
   assign fetch_hdr  = hdr_done && hit && rnw;
   assign fetch_tb   = ev_ok && scl_rise && (st_q == ST_RTB) && !at_limit;

   assign reg_wr    = wbyte_done && !first_w;
   assign reg_wdata = rx_byte;
   assign reg_rd    = fetch_hdr || fetch_tb;
   assign ptr_load  = wbyte_done && first_w;
   assign lim_sel   = rnw_q ? max_rd_len : max_wr_len;

   i3c_tgt_len_guard #(.LEN_W(LEN_W)) u_len (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (hdr_done),
      .bump     (wbyte_done || reg_rd),
      .limit    (lim_sel),
      .none_yet (first_w),
      .at_limit (at_limit)
   );

   i3c_tgt_ptr #(.AW(REG_AW), .AUTO_INC(AUTO_INC)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ptr_load),
      .load_val (rx_byte[REG_AW-1:0]),
      .step     (reg_wr || reg_rd),
      .ptr      (reg_ptr)
   );

   // bit sequencer: sample on rising strobes, drive on falling strobes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         bcnt_q <= '0;
         rx_q   <= '0;
         tx_q   <= '0;
         rnw_q  <= 1'b0;
         sda_oe <= 1'b0;
         sda_o  <= 1'b1;
         sda_pp <= 1'b0;
      end else if (bus_start) begin
         st_q   <= ST_HDR;
         bcnt_q <= '0;
         sda_oe <= 1'b0;
      end else if (bus_stop) begin
         st_q   <= ST_IDLE;
         sda_oe <= 1'b0;
      end else if (scl_rise) begin
         unique case (st_q)
            ST_HDR: begin
               rx_q   <= rx_byte[BYTE_W-2:0];
               bcnt_q <= bcnt_q + BIT_W'(1);
               if (last_bit) begin
                  st_q  <= hit ? ST_ACK : ST_HALT;
                  rnw_q <= rnw;
                  if (fetch_hdr) tx_q <= reg_rdata;
               end
            end
            ST_ACK: begin
               st_q   <= rnw_q ? ST_RDAT : ST_WDAT;
               bcnt_q <= '0;
            end
            ST_WDAT: begin
               rx_q   <= rx_byte[BYTE_W-2:0];
               bcnt_q <= bcnt_q + BIT_W'(1);
               if (last_bit) st_q <= ST_WTB;
            end
            ST_WTB: begin
               st_q <= at_limit ? ST_HALT : ST_WDAT;
            end
            ST_RDAT: begin
               tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
               bcnt_q <= bcnt_q + BIT_W'(1);
               if (last_bit) st_q <= ST_RTB;
            end
            ST_RTB: begin
               if (at_limit) begin
                  st_q <= ST_HALT;
               end else begin
                  tx_q <= reg_rdata;
                  st_q <= ST_RDAT;
               end
            end
            default: ;
         endcase
      end else if (scl_fall) begin
         unique case (st_q)
            ST_ACK: begin
               sda_oe <= 1'b1;
               sda_o  <= 1'b0;
               sda_pp <= 1'b0;
            end
            ST_RDAT: begin
               sda_oe <= 1'b1;
               sda_o  <= tx_q[BYTE_W-1];
               sda_pp <= 1'b1;
            end
            ST_WTB, ST_RTB: begin
               sda_oe <= 1'b1;
               sda_o  <= at_limit;
               sda_pp <= 1'b1;
            end
            default: begin
               sda_oe <= 1'b0;
            end
         endcase
      end
   end
endmodule

// File: rtl/i3c_sdr_tgt_chk.sv
module i3c_sdr_tgt_chk #(
   parameter int REG_AW   = 8,
   parameter bit AUTO_INC = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_rise,
   input logic              scl_fall,
   input logic              bus_start,
   input logic              bus_stop,
   input logic              sda_oe,
   input logic              sda_o,
   input logic              sda_pp,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [REG_AW-1:0] reg_ptr
);
   // R1: open-drain drive only ever pulls low
   p_od_low_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe && !sda_pp) |-> !sda_o);

   // R3: writes land only on a rising sample strobe, never with a read
   p_wr_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> (scl_rise && !reg_rd));

   // R10: fetches only on a rising sample strobe
   p_rd_on_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |-> scl_rise);

   // R9: STOP releases SDA on the next clock
   p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stop |=> !sda_oe);

   // R11: SDA outputs hold unless a fall, START or STOP strobe came first
   p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_fall && !bus_start && !bus_stop) |=> $stable({sda_oe, sda_o, sda_pp}));

   generate
      if (AUTO_INC) begin : g_step
         // R3: pointer advances by one after each register write
         p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
            reg_wr |=> (reg_ptr == REG_AW'($past(reg_ptr) + 1'b1)));
      end
   endgenerate
endmodule

bind i3c_sdr_tgt i3c_sdr_tgt_chk #(.REG_AW(REG_AW), .AUTO_INC(AUTO_INC)) u_chk (.*);

// File: tb/i3c_sdr_tgt_test.sv
module i3c_sdr_tgt_test;
   localparam int REG_AW = 8;
   localparam int LEN_W  = 8;
   localparam logic [6:0] MY_ADDR = 7'h2A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_rise = 1'b0, scl_fall = 1'b0, bus_start = 1'b0, bus_stop = 1'b0;
   logic sda_ctl = 1'b1;
   logic sda_in;
   logic [6:0] dyn_addr = MY_ADDR;
   logic dyn_addr_vld = 1'b1;
   logic [LEN_W-1:0] max_wr_len = 8'd4, max_rd_len = 8'd3;
   logic sda_oe, sda_o, sda_pp, reg_wr, reg_rd;
   logic [REG_AW-1:0] reg_ptr;
   logic [7:0] reg_wdata, reg_rdata;
   logic [7:0] mem [256];

   always #2 clk = ~clk;

   assign sda_in    = sda_oe ? sda_o : sda_ctl;
   assign reg_rdata = mem[reg_ptr];

   i3c_sdr_tgt #(.REG_AW(REG_AW), .LEN_W(LEN_W)) uut (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_in(sda_in), .bus_start(bus_start), .bus_stop(bus_stop),
      .dyn_addr(dyn_addr), .dyn_addr_vld(dyn_addr_vld),
      .max_wr_len(max_wr_len), .max_rd_len(max_rd_len),
      .sda_oe(sda_oe), .sda_o(sda_o), .sda_pp(sda_pp), .reg_ptr(reg_ptr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
   );

   int total = 0, bad = 0, rd_cnt = 0;

   typedef struct { string rq; logic [8:0] v; } item_t;
   item_t      exp_q[$];
   logic [8:0] obs_q[$];
   logic [15:0] wq[$];
   event obs_ev;

   task automatic check(input string rq, input logic [15:0] got, input logic [15:0] want);
      total++;
      if (got !== want) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", rq, got, want);
      end
   endtask

   task automatic expect_item(input string rq, input logic [8:0] want, input logic [8:0] got);
      exp_q.push_back('{rq, want});
      obs_q.push_back(got);
      -> obs_ev;
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(obs_ev);
         while (obs_q.size() > 0 && exp_q.size() > 0) begin
            item_t e;
            logic [8:0] o;
            e = exp_q.pop_front();
            o = obs_q.pop_front();
            check(e.rq, {7'd0, o}, {7'd0, e.v});
         end
      end
   end

   // register model and write scoreboard
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
      end else begin
         if (reg_wr) begin
            mem[reg_ptr] <= reg_wdata;
            if (wq.size() == 0) check("R2 or R5 unexpected write", {reg_ptr, reg_wdata}, 16'hxxxx);
            else check("R3 write", {reg_ptr, reg_wdata}, wq.pop_front());
         end
         if (reg_rd) rd_cnt++;
      end
   end

   // R11: outputs change only after a fall/start/stop strobe
   logic last_strobe = 1'b0;
   logic [2:0] prev_drv = 3'b000;
   always @(posedge clk) last_strobe <= scl_fall | bus_start | bus_stop;
   always @(negedge clk) begin
      if (rst_n && {sda_oe, sda_o, sda_pp} != prev_drv)
         check("R11 output change timing", {15'd0, last_strobe}, 16'd1);
      prev_drv = {sda_oe, sda_o, sda_pp};
   end

   task automatic ctl_bit(input logic v, output logic seen, output logic [2:0] drv);
      @(negedge clk) scl_fall = 1'b1;
      @(negedge clk) scl_fall = 1'b0;
      repeat (2) @(negedge clk);
      sda_ctl = v;
      repeat (2) @(negedge clk);
      seen = sda_in;
      drv  = {sda_oe, sda_oe & sda_o, sda_oe & sda_pp};
      scl_rise = 1'b1;
      @(negedge clk) scl_rise = 1'b0;
   endtask

   task automatic start_cond();
      @(negedge clk) begin sda_ctl = 1'b1; bus_start = 1'b1; end
      @(negedge clk) bus_start = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic stop_cond();
      @(negedge clk) bus_stop = 1'b1;
      @(negedge clk) bus_stop = 1'b0;
      check("R9 release after stop", {15'd0, sda_oe}, 16'd0);
      repeat (2) @(negedge clk);
   endtask

   task automatic send_hdr(input logic [6:0] a, input logic rnw, input logic ack, input string rq);
      logic [7:0] h;
      logic s;
      logic [2:0] d;
      h = {a, rnw};
      for (int i = 7; i >= 0; i--) ctl_bit(h[i], s, d);
      ctl_bit(1'b1, s, d);
      expect_item(rq, ack ? 9'b100 : 9'b000, {6'd0, d});
   endtask

   task automatic wr_byte(input logic [7:0] b, input logic exp_t, input string rq);
      logic s;
      logic [2:0] d;
      logic any_oe;
      any_oe = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         ctl_bit(b[i], s, d);
         any_oe |= d[2];
      end
      expect_item("R4 no drive in write data", 9'd0, {8'd0, any_oe});
      ctl_bit(1'b1, s, d);
      expect_item(rq, {6'd0, 1'b1, exp_t, 1'b1}, {6'd0, d});
   endtask

   task automatic ignored_byte(input string rq);
      logic s;
      logic [2:0] d;
      logic any_oe;
      any_oe = 1'b0;
      for (int i = 0; i < 9; i++) begin
         ctl_bit(1'b1, s, d);
         any_oe |= d[2];
      end
      expect_item(rq, 9'd0, {8'd0, any_oe});
   endtask

   task automatic rd_byte(input logic [7:0] b, input logic exp_t, input string rq);
      logic s;
      logic [2:0] d;
      logic [7:0] got;
      logic all_pp;
      int c0;
      got = 8'd0;
      all_pp = 1'b1;
      for (int i = 0; i < 8; i++) begin
         ctl_bit(1'b1, s, d);
         got = {got[6:0], s};
         all_pp &= d[2] & d[0];
      end
      expect_item(rq, {1'b1, b}, {all_pp, got});
      c0 = rd_cnt;
      ctl_bit(1'b1, s, d);
      expect_item("R7 read T-bit", {6'd0, 1'b1, exp_t, 1'b1}, {6'd0, d});
      @(negedge clk);
      expect_item("R10 fetch count at T-bit", exp_t ? 9'd0 : 9'd1, 9'(rd_cnt - c0));
   endtask

   initial begin
      logic s;
      logic [2:0] d;
      repeat (4) @(negedge clk);
      check("R11 reset oe", {15'd0, sda_oe}, 16'd0);
      check("R11 reset reg_wr", {15'd0, reg_wr}, 16'd0);
      check("R11 reset reg_rd", {15'd0, reg_rd}, 16'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: foreign address, then frame ignored
      start_cond();
      send_hdr(7'h15, 1'b0, 1'b0, "R1 no ack foreign addr");
      ignored_byte("R1 silent after foreign header");
      stop_cond();

      // R2 R3 R4 R5: write with length limit 4
      start_cond();
      send_hdr(MY_ADDR, 1'b0, 1'b1, "R1 ack own addr");
      wr_byte(8'h10, 1'b0, "R2 pointer byte T=0");
      wq.push_back({8'h10, 8'hA1});
      wr_byte(8'hA1, 1'b0, "R4 T=0 byte2");
      wq.push_back({8'h11, 8'hB2});
      wr_byte(8'hB2, 1'b0, "R4 T=0 byte3");
      wq.push_back({8'h12, 8'hC3});
      wr_byte(8'hC3, 1'b1, "R4 T=1 at limit");
      ignored_byte("R5 write after limit ignored");
      stop_cond();

      // R8 R6 R7: pointer set, repeated START, read
      start_cond();
      send_hdr(MY_ADDR, 1'b0, 1'b1, "R1 ack write");
      wr_byte(8'h10, 1'b0, "R2 pointer only");
      start_cond();
      send_hdr(MY_ADDR, 1'b1, 1'b1, "R1 ack read");
      rd_byte(8'hA1, 1'b0, "R8 read from set pointer");
      rd_byte(8'hB2, 1'b0, "R6 next address");
      rd_byte(8'hC3, 1'b1, "R6 third byte");
      ignored_byte("R7 silent after last read");
      stop_cond();

      // R8: read continues from pointer 0x13, limit 2
      max_rd_len = 8'd2;
      start_cond();
      send_hdr(MY_ADDR, 1'b1, 1'b1, "R1 ack read");
      rd_byte(8'h13 ^ 8'h5A, 1'b0, "R8 pointer kept across frames");
      rd_byte(8'h14 ^ 8'h5A, 1'b1, "R6 second byte");
      stop_cond();

      // R9: START mid-byte aborts without a write
      max_rd_len = 8'd1;
      start_cond();
      send_hdr(MY_ADDR, 1'b0, 1'b1, "R1 ack write");
      wr_byte(8'h20, 1'b0, "R2 pointer 0x20");
      for (int i = 0; i < 4; i++) ctl_bit(1'b1, s, d);
      start_cond();
      send_hdr(MY_ADDR, 1'b1, 1'b1, "R9 header after abort");
      rd_byte(8'h20 ^ 8'h5A, 1'b1, "R9 no write from aborted byte");
      stop_cond();

      // R1: address not yet valid
      dyn_addr_vld = 1'b0;
      start_cond();
      send_hdr(MY_ADDR, 1'b0, 1'b0, "R1 no ack when invalid");
      ignored_byte("R1 silent when invalid");
      stop_cond();
      dyn_addr_vld = 1'b1;

      // R3: pointer wrap
      max_rd_len = 8'd2;
      start_cond();
      send_hdr(MY_ADDR, 1'b0, 1'b1, "R1 ack write");
      wr_byte(8'hFF, 1'b0, "R2 pointer 0xFF");
      wq.push_back({8'hFF, 8'h11});
      wr_byte(8'h11, 1'b0, "R4 T=0");
      wq.push_back({8'h00, 8'h22});
      wr_byte(8'h22, 1'b0, "R3 wrapped write");
      stop_cond();
      start_cond();
      send_hdr(MY_ADDR, 1'b0, 1'b1, "R1 ack write");
      wr_byte(8'hFF, 1'b0, "R2 pointer 0xFF");
      start_cond();
      send_hdr(MY_ADDR, 1'b1, 1'b1, "R1 ack read");
      rd_byte(8'h11, 1'b0, "R3 read 0xFF");
      rd_byte(8'h22, 1'b1, "R3 read wrapped 0x00");
      stop_cond();

      repeat (4) @(negedge clk);
      check("R3 pending writes", 16'(wq.size()), 16'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog R11 actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule